// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit CPU and the memories of a small system. It takes each 16-bit CPU address and works out which store is meant and what local offset it carries. It then raises one select line together with a read or write strobe towards that store. The stores include two cartridge ROM windows, video RAM, external RAM, two work-RAM windows and their upper mirror, the sprite attribute table, I/O, high RAM and the interrupt-enable register. The block itself holds the work-RAM bank register, which sets the page shown in the switchable work-RAM window.

A sprite DMA engine may own part of the internal buses. While it runs, the block compares the bus that the DMA source lives on with the bus of each CPU access. A collision turns the access into a dummy, as does any touch of the sprite table. A variant input picks which of two bus layouts applies.

Read data comes back through a small read-phase state machine. A read issued in one cycle is answered in the next, with `cpu_rvalid` high. In the state ST_FETCH the answer is the selected store's data. In ST_FILL it is the constant 0xFF. In ST_REG it is the bank register. ST_IDLE means no read is pending. From every state, the machine moves to ST_FETCH when a read is routed to a store, to ST_REG when a read targets the bank register, to ST_FILL when a read is suppressed, and to ST_IDLE when no read is presented.

Top module: `amr_map_router`

## Requirements
- R1: Select bit encoding is bit0 fixed ROM, bit1 banked ROM, bit2 video RAM, bit3 external RAM, bit4 work-RAM page 0, bit5 switchable work-RAM, bit6 sprite table, bit7 I/O, bit8 high RAM, bit9 interrupt-enable. Addresses 0x0000-0x3FFF select bit0 and 0x4000-0x7FFF select bit1, both with offset addr[13:0]. Addresses 0x8000-0x9FFF select bit2 with offset addr[12:0]. Addresses 0xC000-0xCFFF select bit4 with offset addr[11:0]. Whenever a strobe is high, exactly one select bit is set.
- R2: Addresses 0xD000-0xDFFF select bit5 with offset {bank[2:0], addr[11:0]}.
- R3: Addresses 0xE000-0xEFFF act like 0xC000-0xCFFF (bit4). Addresses 0xF000-0xFDFF act like the switchable window (bit5, banked offset).
- R4: The bank register sits at 0xFF70 and is not sent to any store. A write stores wdata[2:0], but a value of 0 stores 1. Reset leaves it at 1. A read returns {5'b11111, bank}.
- R5: 0xFE00-0xFE9F selects bit6 with offset addr[7:0] only when video_mode is 0 or 1. Otherwise reads give 0xFF and writes raise no strobe.
- R6: 0xFEA0-0xFEFF selects nothing. Reads there return 0xFF.
- R7: When dma_busy is high, each 8 KB block (addr[15:13]) belongs to a bus. With enhanced low, block 4 is video bus, block 7 is CPU-side and every other block is main bus. If the DMA source block's bus is not CPU-side and equals the access block's bus, the access selects nothing and a read returns 0xFF.
- R8: With enhanced high, block 6 (0xC000-0xDFFF) moves to its own RAM bus. The R7 rule then uses that table.
- R9: When dma_busy is high, any access to 0xFE00-0xFE9F is suppressed, whatever the source bus.
- R10: When xram_en is low, 0xA000-0xBFFF selects nothing and reads return 0xFF. When it is high, bit3 is selected with offset addr[12:0].
- R11: A read raises mem_re in its request cycle. In the next cycle cpu_rvalid is high and cpu_rdata carries mem_rdata, 0xFF or the bank value, as routed. After reset, and one cycle after a cycle with no read, cpu_rvalid is low.
- R12: If cpu_rd and cpu_wr are high together, only the read is performed: mem_we stays low and the bank register keeps its value.
- R13: 0xFF00-0xFF7F (except 0xFF70) selects bit7, and 0xFF80-0xFFFE selects bit8, both with offset addr[6:0]. 0xFFFF selects bit9 with offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data phase, one cycle after cpu_rd |
| video_mode | input | 2 | Current video mode, 0..3 |
| dma_busy | input | 1 | Sprite DMA in progress |
| dma_src_blk | input | 3 | Upper three bits of the DMA source address |
| enhanced | input | 1 | Selects the enhanced bus layout |
| xram_en | input | 1 | External RAM enabled |
| mem_sel | output | 10 | One-hot store select (R1 encoding) |
| mem_offset | output | 15 | Offset inside the selected store |
| mem_re | output | 1 | Read strobe to the selected store |
| mem_we | output | 1 | Write strobe to the selected store |
| mem_wdata | output | 8 | Write data to the stores |
| mem_rdata | input | 8 | Data returned by the store one cycle after mem_re |
| wram_bank | output | 3 | Current switchable work-RAM page |

## Verification
Select lines, offsets and strobes are combinational. The bench checks them 1 ns after it drives a request, in the same cycle. Read answers are due one clock edge later, so the bench waits for that edge and samples cpu_rvalid and cpu_rdata at the following falling edge. A bank register write takes effect at the edge that ends its cycle. The bench's own copy of the bank is updated only after that edge, so later expected offsets and readbacks use the new page. The bench's memory model answers one cycle after mem_re, which matches the ST_FETCH data phase.

// File: rtl/amr_pkg.sv
package amr_pkg;

    localparam int NSEL      = 10;
    localparam int SEL_ROM0  = 0;
    localparam int SEL_ROMX  = 1;
    localparam int SEL_VRAM  = 2;
    localparam int SEL_XRAM  = 3;
    localparam int SEL_WRAM0 = 4;
    localparam int SEL_WRAMX = 5;
    localparam int SEL_OAM   = 6;
    localparam int SEL_IO    = 7;
    localparam int SEL_HRAM  = 8;
    localparam int SEL_IE    = 9;

    localparam logic [15:0] OAM_BASE  = 16'hFE00;
    localparam logic [15:0] OAM_END   = 16'hFEA0;
    localparam logic [15:0] IO_BASE   = 16'hFF00;
    localparam logic [15:0] HRAM_BASE = 16'hFF80;
    localparam logic [15:0] IE_ADDR   = 16'hFFFF;
    localparam logic [15:0] BANK_ADDR = 16'hFF70;
    localparam logic [7:0]  FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        BUS_CPU,
        BUS_MAIN,
        BUS_VID,
        BUS_WRAM
    } bus_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FILL,
        ST_REG
    } rd_state_e;

    function automatic bus_e bus_of(input logic [2:0] blk, input logic enh);
        bus_e b;
        unique case (blk)
            3'd4:    b = BUS_VID;
            3'd6:    b = enh ? BUS_WRAM : BUS_MAIN;
            3'd7:    b = BUS_CPU;
            default: b = BUS_MAIN;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/amr_region_decode.sv
module amr_region_decode
    import amr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 3,
    parameter int OFS_W  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [1:0]        video_mode,
    input  logic              xram_en,
    output logic [NSEL-1:0]   sel,
    output logic [OFS_W-1:0]  offset,
    output logic              hit_reg
);

    localparam int PAGE_W = 12;

    logic oam_open;
    assign oam_open = (video_mode < 2'd2);

    always_comb begin
        sel     = '0;
        offset  = '0;
        hit_reg = 1'b0;
        unique case (addr[ADDR_W-1:ADDR_W-4])
            4'h0, 4'h1, 4'h2, 4'h3: begin
                sel[SEL_ROM0] = 1'b1;
                offset        = OFS_W'(addr[13:0]);
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                sel[SEL_ROMX] = 1'b1;
                offset        = OFS_W'(addr[13:0]);
            end
            4'h8, 4'h9: begin
                sel[SEL_VRAM] = 1'b1;
                offset        = OFS_W'(addr[12:0]);
            end
            4'hA, 4'hB: begin
                sel[SEL_XRAM] = xram_en;
                offset        = OFS_W'(addr[12:0]);
            end
            4'hC, 4'hE: begin
                sel[SEL_WRAM0] = 1'b1;
                offset         = OFS_W'(addr[PAGE_W-1:0]);
            end
            4'hD: begin
                sel[SEL_WRAMX] = 1'b1;
                offset         = OFS_W'({bank, addr[PAGE_W-1:0]});
            end
            default: begin
                if (addr < OAM_BASE) begin
                    sel[SEL_WRAMX] = 1'b1;
                    offset         = OFS_W'({bank, addr[PAGE_W-1:0]});
                end else if (addr < OAM_END) begin
                    sel[SEL_OAM] = oam_open;
                    offset       = OFS_W'(addr[7:0]);
                end else if (addr < IO_BASE) begin
                    sel = '0;
                end else if (addr == BANK_ADDR) begin
                    hit_reg = 1'b1;
                end else if (addr < HRAM_BASE) begin
                    sel[SEL_IO] = 1'b1;
                    offset      = OFS_W'(addr[6:0]);
                end else if (addr < IE_ADDR) begin
                    sel[SEL_HRAM] = 1'b1;
                    offset        = OFS_W'(addr[6:0]);
                end else begin
                    sel[SEL_IE] = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/amr_dma_guard.sv
module amr_dma_guard
    import amr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dma_busy,
    input  logic [BLK_W-1:0]  dma_src_blk,
    input  logic              enhanced,
    output logic              blocked
);

    localparam int NBLK = 1 << BLK_W;

    bus_e blk_bus [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_bus_tbl
        assign blk_bus[b] = bus_of(BLK_W'(b), enhanced);
    end

    bus_e src_bus;
    bus_e acc_bus;
    logic oam_hit;
    logic bus_clash;

    assign src_bus   = blk_bus[dma_src_blk];
    assign acc_bus   = blk_bus[addr[ADDR_W-1:ADDR_W-BLK_W]];
    assign oam_hit   = (addr >= OAM_BASE) && (addr < OAM_END);
    assign bus_clash = (src_bus != BUS_CPU) && (src_bus == acc_bus);
    assign blocked   = dma_busy && (bus_clash || oam_hit);

endmodule

// File: rtl/amr_bank_reg.sv
module amr_bank_reg #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank
);

    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank <= BANK_ONE;
        end else if (load) begin
            bank <= (wdata == '0) ? BANK_ONE : wdata;
        end
    end

    assert_bank_nonzero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        bank != '0);

    assert_bank_load_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        (load && wdata != '0) |=> (bank == $past(wdata)));

endmodule

// File: rtl/amr_map_router.sv
module amr_map_router
    import amr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int BANK_W = 3,
    parameter int BLK_W  = 3,
    parameter int OFS_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    input  logic [1:0]        video_mode,
    input  logic              dma_busy,
    input  logic [BLK_W-1:0]  dma_src_blk,
    input  logic              enhanced,
    input  logic              xram_en,
    output logic [NSEL-1:0]   mem_sel,
    output logic [OFS_W-1:0]  mem_offset,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [BANK_W-1:0] wram_bank
);

    localparam int PAD_W = DATA_W - BANK_W;

    logic [NSEL-1:0] raw_sel;
    logic            hit_reg;
    logic            blocked;
    logic            routed;
    logic            wr_go;
    rd_state_e       state_q;
    rd_state_e       state_d;

    amr_region_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W)
    ) u_decode (
        .addr(cpu_addr), .bank(wram_bank), .video_mode(video_mode),
        .xram_en(xram_en), .sel(raw_sel), .offset(mem_offset), .hit_reg(hit_reg)
    );

    amr_dma_guard #(
        .ADDR_W(ADDR_W), .BLK_W(BLK_W)
    ) u_guard (
        .addr(cpu_addr), .dma_busy(dma_busy), .dma_src_blk(dma_src_blk),
        .enhanced(enhanced), .blocked(blocked)
    );

    amr_bank_reg #(
        .BANK_W(BANK_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .load(wr_go && hit_reg),
        .wdata(cpu_wdata[BANK_W-1:0]), .bank(wram_bank)
    );

    assign wr_go     = cpu_wr && !cpu_rd;
    assign mem_sel   = blocked ? '0 : raw_sel;
    assign routed    = |mem_sel;
    assign mem_re    = cpu_rd && routed;
    assign mem_we    = wr_go && routed;
    assign mem_wdata = cpu_wdata;

    always_comb begin
        state_d = ST_IDLE;
        if (cpu_rd) begin
            if (routed) begin
                state_d = ST_FETCH;
            end else if (hit_reg) begin
                state_d = ST_REG;
            end else begin
                state_d = ST_FILL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cpu_rvalid = 1'b1;
        cpu_rdata  = FILL_BYTE;
        unique case (state_q)
            ST_IDLE: begin
                cpu_rvalid = 1'b0;
            end
            ST_FETCH: begin
                cpu_rdata = mem_rdata;
            end
            ST_FILL: begin
                cpu_rdata = FILL_BYTE;
            end
            ST_REG: begin
                cpu_rdata = {{PAD_W{1'b1}}, wram_bank};
            end
        endcase
    end

    assert_sel_onehot_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> ($countones(mem_sel) == 1));

    assert_oam_mode_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        (video_mode >= 2'd2 && cpu_addr >= OAM_BASE && cpu_addr < OAM_END)
        |-> !mem_sel[SEL_OAM]);

    assert_dma_oam_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (dma_busy && cpu_addr >= OAM_BASE && cpu_addr < OAM_END) |-> (mem_sel == '0));

    assert_rvalid_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> cpu_rvalid);

    assert_idle_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> !cpu_rvalid);

    assert_fill_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && mem_sel == '0 && cpu_addr != BANK_ADDR) |=> (cpu_rdata == FILL_BYTE));

    assert_rdwr_R12 : assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_wr) |-> !mem_we);

endmodule

// File: tb/amr_map_router_tb_top.sv
`timescale 1ns/1ps
module amr_map_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic [1:0]  video_mode = '0;
    logic        dma_busy = 1'b0;
    logic [2:0]  dma_src_blk = '0;
    logic        enhanced = 1'b0;
    logic        xram_en = 1'b1;
    logic [9:0]  mem_sel;
    logic [14:0] mem_offset;
    logic        mem_re;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  wram_bank;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [2:0] bank_m = 3'd1;

    always #10 clk = ~clk;

    amr_map_router dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .video_mode(video_mode), .dma_busy(dma_busy), .dma_src_blk(dma_src_blk),
        .enhanced(enhanced), .xram_en(xram_en), .mem_sel(mem_sel), .mem_offset(mem_offset),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wram_bank(wram_bank)
    );

    function automatic int sel_idx(input logic [9:0] s);
        for (int i = 0; i < 10; i++) if (s[i]) return i;
        return 15;
    endfunction

    function automatic logic [7:0] pat(input int idx, input logic [14:0] o);
        return o[7:0] ^ {1'b0, o[14:8]} ^ 8'(idx * 37 + 11);
    endfunction

    always @(posedge clk) if (mem_re) mem_rdata <= pat(sel_idx(mem_sel), mem_offset);

    function automatic int bus_ref(input logic [2:0] blk, input bit enh);
        if (blk == 3'd7) return 0;
        if (blk == 3'd4) return 2;
        if (blk == 3'd6 && enh) return 3;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic exp_route(input logic [15:0] a, input logic [1:0] md, input bit dma,
                             input logic [2:0] src, input bit enh, input bit xen,
                             output logic [9:0] s, output logic [14:0] o,
                             output bit isreg, output string tag);
        s = '0; o = '0; isreg = 0; tag = "R1";
        if (a < 16'h4000) begin s[0] = 1; o = {1'b0, a[13:0]}; end
        else if (a < 16'h8000) begin s[1] = 1; o = {1'b0, a[13:0]}; end
        else if (a < 16'hA000) begin s[2] = 1; o = {2'b0, a[12:0]}; end
        else if (a < 16'hC000) begin tag = "R10"; if (xen) begin s[3] = 1; o = {2'b0, a[12:0]}; end end
        else if (a < 16'hD000) begin s[4] = 1; o = {3'b0, a[11:0]}; end
        else if (a < 16'hE000) begin tag = "R2"; s[5] = 1; o = {bank_m, a[11:0]}; end
        else if (a < 16'hF000) begin tag = "R3"; s[4] = 1; o = {3'b0, a[11:0]}; end
        else if (a < 16'hFE00) begin tag = "R3"; s[5] = 1; o = {bank_m, a[11:0]}; end
        else if (a < 16'hFEA0) begin tag = "R5"; if (md < 2) begin s[6] = 1; o = {7'b0, a[7:0]}; end end
        else if (a < 16'hFF00) begin tag = "R6"; end
        else if (a == 16'hFF70) begin tag = "R4"; isreg = 1; end
        else if (a < 16'hFF80) begin tag = "R13"; s[7] = 1; o = {8'b0, a[6:0]}; end
        else if (a < 16'hFFFF) begin tag = "R13"; s[8] = 1; o = {8'b0, a[6:0]}; end
        else begin tag = "R13"; s[9] = 1; end
        if (dma) begin
            int sb, ab;
            sb = bus_ref(src, enh);
            ab = bus_ref(a[15:13], enh);
            if (a >= 16'hFE00 && a < 16'hFEA0) begin s = '0; tag = "R9"; end
            else if (sb != 0 && sb == ab) begin s = '0; tag = (enh && a[15:13] == 3'd6) ? "R8" : "R7"; end
        end
    endtask

    task automatic access(input logic [15:0] a, input bit rd, input bit wr, input logic [7:0] wd,
                          input logic [1:0] md, input bit dma, input logic [2:0] src,
                          input bit enh, input bit xen);
        logic [9:0] es; logic [14:0] eo; bit isreg; string tag; string t2;
        logic [7:0] erd;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd; video_mode = md;
        dma_busy = dma; dma_src_blk = src; enhanced = enh; xram_en = xen;
        exp_route(a, md, dma, src, enh, xen, es, eo, isreg, tag);
        #1;
        chk(mem_sel == es, tag, "mem_sel", mem_sel, es);
        if (es != '0) chk(mem_offset == eo, tag, "mem_offset", mem_offset, eo);
        chk(mem_re == (rd && es != '0), tag, "mem_re", mem_re, rd && es != '0);
        t2 = (rd && wr) ? "R12" : tag;
        chk(mem_we == (wr && !rd && es != '0), t2, "mem_we", mem_we, wr && !rd && es != '0);
        if (isreg) erd = {5'b11111, bank_m};
        else if (es != '0) erd = pat(sel_idx(es), eo);
        else erd = 8'hFF;
        @(posedge clk);
        if (isreg && wr && !rd) bank_m = (wd[2:0] == 3'd0) ? 3'd1 : wd[2:0];
        @(negedge clk);
        chk(cpu_rvalid == rd, "R11", "cpu_rvalid", cpu_rvalid, rd);
        if (rd) chk(cpu_rdata == erd, isreg ? "R4" : (es != '0 ? "R11" : tag), "cpu_rdata", cpu_rdata, erd);
        chk(wram_bank == bank_m, (rd && wr) ? "R12" : "R4", "wram_bank", wram_bank, bank_m);
        cpu_rd = 0; cpu_wr = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_rvalid == 1'b0, "R11", "reset rvalid", cpu_rvalid, 0);
        chk(wram_bank == 3'd1, "R4", "reset bank", wram_bank, 1);

        // R4 bank register writes, zero maps to one, readback pads with ones
        access(16'hFF70, 0, 1, 8'h0D, 0, 0, 0, 0, 1);
        access(16'hFF70, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        access(16'hD123, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        access(16'hFF70, 0, 1, 8'hF8, 0, 0, 0, 0, 1);
        access(16'hFF70, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        // R12 read and write together keep the bank
        access(16'hFF70, 1, 1, 8'h06, 0, 0, 0, 0, 1);
        access(16'hC010, 1, 1, 8'h33, 0, 0, 0, 0, 1);
        access(16'hFF70, 0, 1, 8'h05, 0, 0, 0, 0, 1);
        // R3 mirrors
        access(16'hE123, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        access(16'hF456, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        // R5 sprite table gated by mode
        access(16'hFE10, 1, 0, 8'h00, 1, 0, 0, 0, 1);
        access(16'hFE10, 1, 0, 8'h00, 2, 0, 0, 0, 1);
        access(16'hFE10, 0, 1, 8'h12, 3, 0, 0, 0, 1);
        // R6 gap
        access(16'hFEA5, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        // R10 external RAM enable
        access(16'hA050, 1, 0, 8'h00, 0, 0, 0, 0, 0);
        access(16'hA050, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        // R13 upper page
        access(16'hFF05, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        access(16'hFF85, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        access(16'hFFFF, 1, 0, 8'h00, 0, 0, 0, 0, 1);
        // R7 / R8 / R9 bus clash during DMA
        access(16'hC100, 1, 0, 8'h00, 0, 1, 3'd0, 0, 1);
        access(16'hC100, 1, 0, 8'h00, 0, 1, 3'd0, 1, 1);
        access(16'hC100, 1, 0, 8'h00, 0, 1, 3'd6, 1, 1);
        access(16'h8100, 1, 0, 8'h00, 0, 1, 3'd4, 0, 1);
        access(16'h0100, 1, 0, 8'h00, 0, 1, 3'd7, 0, 1);
        access(16'hFE10, 1, 0, 8'h00, 0, 1, 3'd7, 0, 1);
        access(16'hFF85, 1, 0, 8'h00, 0, 1, 3'd0, 0, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a; int k; bit rd; bit wr;
            k = $urandom % 8;
            if (k == 0) a = 16'hFE00 | 16'($urandom % 512);
            else if (k == 1) a = 16'hFF70;
            else a = 16'($urandom);
            k = $urandom % 8;
            rd = (k < 4) || (k == 7);
            wr = (k >= 4);
            access(a, rd, wr, 8'($urandom), 2'($urandom), ($urandom % 4) == 0,
                   3'($urandom), 1'($urandom), ($urandom % 4) != 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule